// File: doc/BRIEF.md
# Narrow-Operand Gated Integer Unit

This block is the operand front end and execute stage of a 64-bit integer unit that saves switching power when both source operands are small. Each operand is held in a split register: a 16-bit low part and a 48-bit high part. When both operands have all-zero upper 48 bits, the high parts are not loaded. The unit computes only the low 16 bits, and the upper 48 result bits are forced to zero.

Narrow mode is only used when it gives the exact answer. The logical operations are always exact under it. An add is exact only when the low 16-bit sum produces no carry out of bit 15. When there is such a carry, the operation runs at full width, and for that operation the high registers load as usual.

The clock gate is built as a load enable on the high registers. A counter reports how many accepted operations used the narrow path, so that the activity saved can be measured.

Top module: `narrow_gate_alu`

## Requirements
- R1: After reset, `res_valid` is 0, `res_narrow` is 0, `result` is 0 and `gated_cnt` is 0.
- R2: `res_valid` is 1 on the cycle after an edge at which `in_valid` was 1, and 0 otherwise.
- R3: The result equals the full 64-bit value of the selected operation on the accepted operands. The `op_sel` encoding is: 0 for add modulo 2^64, 1 for bitwise AND, 2 for bitwise OR and 3 for bitwise XOR.
- R4: `res_narrow` is 1 exactly when two conditions hold for the accepted operands. First, bits 63:16 of both operands are zero. Second, the operation is not an add, or the add of their bits 15:0 carries nothing out of bit 15.
- R5: Whenever `res_narrow` is 1, `result[63:16]` is zero.
- R6: An add of two narrow operands whose low 16-bit sum carries out of bit 15 is not narrow, and it returns the exact 17-bit sum.
- R7: `gated_cnt` rises by one for each accepted operation that is narrow, and it wraps modulo 2^CNT_W. Otherwise it is unchanged.
- R8: While `in_valid` is 0, `result`, `res_narrow` and `gated_cnt` hold their values, whatever is on the operand and op inputs.
- R9: A narrow operation that follows a wide one carries no upper bits from the earlier wide operands into its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The operands and op are accepted at this edge |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sel | input | 2 | Operation: 0 add, 1 AND, 2 OR, 3 XOR |
| res_valid | output | 1 | The result belongs to an operation accepted on the previous edge |
| result | output | 64 | Result of the last accepted operation |
| res_narrow | output | 1 | The last accepted operation used the gated narrow path |
| gated_cnt | output | 16 | Count of narrow operations accepted |

## Verification
An operation presented at a clock edge has `res_valid`, `result` and `res_narrow` due after that edge, and `gated_cnt` already includes it. The bench drives inputs on the falling edge. On the next falling edge it compares every output against a behavioural model that has stepped once for that rising edge, so each result is checked exactly one register stage after its stimulus. Idle cycles drive random junk on the operand inputs to show that the held outputs do not move. Random traffic mixes narrow and wide operands, and directed cases cover the add carry out of bit 15 and a narrow operation that follows a wide one.

// File: rtl/nga_pkg.sv
package nga_pkg;
    localparam int DATA_W = 64;
    localparam int LO_W   = 16;
    localparam int HI_W   = DATA_W - LO_W;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } op_e;
endpackage

// File: rtl/nga_zero_detect.sv
module nga_zero_detect #(
    parameter int W = 48
) (
    input  logic [W-1:0] field,
    output logic         is_zero
);
    always_comb begin
        is_zero = ~|field;
    end
endmodule

// File: rtl/nga_split_reg.sv
module nga_split_reg #(
    parameter int LO_W = 16,
    parameter int HI_W = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_en,
    input  logic                 hi_en,
    input  logic [LO_W+HI_W-1:0] d,
    output logic [LO_W-1:0]      lo_q,
    output logic [HI_W-1:0]      hi_q
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (lo_en) r_d.lo = d[LO_W-1:0];
        if (hi_en) r_d.hi = d[LO_W+HI_W-1:LO_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lo_q = r_q.lo;
    assign hi_q = r_q.hi;

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_en |=> $stable(hi_q)); // R9
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_en |=> $stable(lo_q)); // R8
endmodule

// File: rtl/nga_exec.sv
module nga_exec
    import nga_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 48
) (
    input  logic [LO_W-1:0]      a_lo,
    input  logic [HI_W-1:0]      a_hi,
    input  logic [LO_W-1:0]      b_lo,
    input  logic [HI_W-1:0]      b_hi,
    input  op_e                  op,
    input  logic                 narrow,
    output logic [LO_W+HI_W-1:0] y
);
    localparam int W = LO_W + HI_W;

    logic [W-1:0] a_full, b_full, full;

    always_comb begin
        a_full = {a_hi, a_lo};
        b_full = {b_hi, b_lo};
        unique case (op)
            OP_ADD:  full = a_full + b_full;
            OP_AND:  full = a_full & b_full;
            OP_OR:   full = a_full | b_full;
            default: full = a_full ^ b_full;
        endcase
        y = {narrow ? {HI_W{1'b0}} : full[W-1:LO_W], full[LO_W-1:0]};
    end
endmodule

// File: rtl/narrow_gate_alu.sv
module narrow_gate_alu
    import nga_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        op_sel,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              res_narrow,
    output logic [CNT_W-1:0]  gated_cnt
);
    localparam int N_OPND = 2;

    typedef struct packed {
        logic             vld;
        logic             narrow;
        op_e              op;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    logic [N_OPND-1:0][DATA_W-1:0] opnd;
    logic [N_OPND-1:0]             zero_hi;
    logic [N_OPND-1:0][LO_W-1:0]   lo_q;
    logic [N_OPND-1:0][HI_W-1:0]   hi_q;
    logic [LO_W:0]                 lo_sum;
    logic                          lo_carry;
    logic                          gate;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        nga_zero_detect #(.W(HI_W)) u_zd (
            .field   (opnd[g][DATA_W-1:LO_W]),
            .is_zero (zero_hi[g])
        );
        nga_split_reg #(.LO_W(LO_W), .HI_W(HI_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .lo_en (in_valid),
            .hi_en (in_valid & ~gate),
            .d     (opnd[g]),
            .lo_q  (lo_q[g]),
            .hi_q  (hi_q[g])
        );
    end

    always_comb begin
        lo_sum   = {1'b0, op_a[LO_W-1:0]} + {1'b0, op_b[LO_W-1:0]};
        lo_carry = lo_sum[LO_W];
        gate     = (&zero_hi) & ~((op_e'(op_sel) == OP_ADD) & lo_carry);

        s_d     = s_q;
        s_d.vld = in_valid;
        if (in_valid) begin
            s_d.narrow = gate;
            s_d.op     = op_e'(op_sel);
            if (gate) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{vld: 1'b0, narrow: 1'b0, op: OP_ADD, cnt: '0};
        else        s_q <= s_d;
    end

    nga_exec #(.LO_W(LO_W), .HI_W(HI_W)) u_exec (
        .a_lo   (lo_q[0]),
        .a_hi   (hi_q[0]),
        .b_lo   (lo_q[1]),
        .b_hi   (hi_q[1]),
        .op     (s_q.op),
        .narrow (s_q.narrow),
        .y      (result)
    );

    assign res_valid  = s_q.vld;
    assign res_narrow = s_q.narrow;
    assign gated_cnt  = s_q.cnt;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R2
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid); // R2
    AST_GATE_NARROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a[DATA_W-1:LO_W] != '0 || op_b[DATA_W-1:LO_W] != '0)) |=> !res_narrow); // R4
    AST_CARRY_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && ({1'b0, op_a[LO_W-1:0]} + {1'b0, op_b[LO_W-1:0]}) > (LO_W+1)'({LO_W{1'b1}}))
        |=> !res_narrow); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_narrow |-> (result[DATA_W-1:LO_W] == '0)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gated_cnt) && $stable(result)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (gated_cnt == $past(gated_cnt) + CNT_W'(res_narrow))); // R7
endmodule

// File: tb/sim_narrow_gate_alu.sv
module sim_narrow_gate_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  op_sel = '0;
    logic        res_valid;
    logic [63:0] result;
    logic        res_narrow;
    logic [15:0] gated_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        exp_vld = 0;
    logic [63:0] exp_res = '0;
    logic        exp_nar = 0;
    logic [15:0] exp_cnt = '0;
    bit          exp_carry = 0;

    always #10 clk = ~clk;

    narrow_gate_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sel(op_sel), .res_valid(res_valid), .result(result),
        .res_narrow(res_narrow), .gated_cnt(gated_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] o);
        case (o)
            2'd0: return a + b;
            2'd1: return a & b;
            2'd2: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic compare(input bit idle_prev);
        chk("R2 res_valid", 64'(res_valid), 64'(exp_vld));
        chk(idle_prev ? "R8 held result" : "R3 result", result, exp_res);
        chk(idle_prev ? "R8 held narrow" : "R4 narrow", 64'(res_narrow), 64'(exp_nar));
        chk(idle_prev ? "R8 held count" : "R7 count", 64'(gated_cnt), 64'(exp_cnt));
        if (exp_nar) chk("R5 upper zero", 64'(result[63:16]), 64'd0);
        if (exp_carry) chk("R6 carry sum bit16", 64'(result[16]), 64'd1);
    endtask

    task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b, input logic [1:0] o);
        bit n;
        logic [16:0] s;
        @(negedge clk);
        compare(!exp_vld);
        in_valid = v; op_a = a; op_b = b; op_sel = o;
        exp_vld = v;
        exp_carry = 0;
        if (v) begin
            s = {1'b0, a[15:0]} + {1'b0, b[15:0]};
            n = (a[63:16] == 0) && (b[63:16] == 0) && !(o == 2'd0 && s[16]);
            exp_carry = (a[63:16] == 0) && (b[63:16] == 0) && o == 2'd0 && s[16];
            exp_res = ref_op(a, b, o);
            exp_nar = n;
            if (n) exp_cnt = exp_cnt + 16'd1;
        end
    endtask

    function automatic logic [63:0] rnd_opnd();
        logic [63:0] x;
        x = {$urandom, $urandom};
        case ($urandom % 3)
            0: return {48'd0, x[15:0]};
            1: return x;
            default: return {32'd0, x[31:0]};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 res_valid", 64'(res_valid), 64'd0);
        chk("R1 result", result, 64'd0);
        chk("R1 narrow", 64'(res_narrow), 64'd0);
        chk("R1 count", 64'(gated_cnt), 64'd0);
        rst_n = 1'b1;
        // narrow add without carry, then narrow add with carry out of bit 15 (R6)
        step(1, 64'h0000_0000_0000_0012, 64'h0000_0000_0000_0034, 2'd0);
        step(1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 2'd0);
        // wide XOR then narrow AND: stale upper bits must not leak (R9)
        step(1, 64'hDEAD_BEEF_1234_5678, 64'hFFFF_0000_FFFF_0000, 2'd3);
        step(1, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_FF00, 2'd1);
        @(negedge clk);
        chk("R9 no stale upper bits", result, 64'h0000_0000_0000_F000);
        compare(0);
        in_valid = 0;
        exp_vld = 0; exp_carry = 0;
        // idle cycles with junk on the inputs (R8)
        for (int i = 0; i < 4; i++) step(0, {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom));
        step(1, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 2'd2);
        step(1, 64'h0001_0000_0000_0001, 64'h0000_0000_0000_0001, 2'd2);
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, rnd_opnd(), rnd_opnd(), 2'($urandom));
        step(0, '0, '0, 2'd0);
        @(negedge clk);
        compare(1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule